// File: doc/BRIEF.md
# Hierarchical Interrupt Request Controller

This block gathers event pulses from eighteen interrupt sources and gives a small 8-bit CPU core one prioritised request with its vector. Each source has four event inputs, each gated by its own peripheral-level mask bit. A multi-event peripheral uses several of them. A single-event peripheral uses one, and that mask bit acts as its local enable. Two peripherals that share one source each drive a different event input of it. Any unmasked event sets the source's flag. A flag leads to a request only when the source's individual enable and the global enable are both 1.

Sources are grouped three at a time into six priority groups. Each group has a 2-bit level. The highest level wins, and on equal levels the lowest source index wins. A per-level in-service set tracks nesting. A new request is raised only if its level is strictly above the highest level in service. The CPU acknowledges a request to enter it and pulses return to leave the innermost level. Software reads and writes flags, enables, levels and masks through a byte-wide register port.

Top module: `irq_ctrl`

## Requirements
- R1: An event input `evt_i[4*s+e]` that is high while mask bit e of source s is 1 sets flag s at that clock edge. Flag s reads back at address s/8, bit s%8. Several unmasked events of one source set the same single flag.
- R2: An event whose mask bit is 0 leaves the flag unchanged. Mask bit e of source s is flat mask bit 4*s+e, held at address 9+(4*s+e)/8, bit (4*s+e)%8.
- R3: Writing 1 to a flag bit at addresses 0 to 2 clears that flag, and writing 0 leaves it. If a set and a clear reach the same flag in one cycle, the flag ends up 1.
- R4: A flag raises a request only when its enable bit (address 3+s/8, bit s%8) is 1 and the global enable (address 6, bit 0) is 1.
- R5: Source s belongs to group s/3. The group's 2-bit level is flat priority bits 2g+1:2g, held at address 7+(2g)/8. Among eligible sources the highest level wins, and on equal levels the lowest index wins.
- R6: `irq_o` rises one clock edge after a flag becomes eligible. `vec_o` equals 3+8*index and `src_o` equals the index. Both stay stable, and `irq_o` stays high, until the edge at which `ack_i` is sampled high.
- R7: An acknowledge marks the granted level as in service. While any level is in service, only a source with a strictly higher level can raise a request.
- R8: A `reti_i` pulse removes the highest level from the in-service set. A `reti_i` with nothing in service has no effect.
- R9: After reset all flags, enables, masks, levels, the global enable and the in-service set are 0, and `irq_o` is 0.
- R10: `rd_data_o` shows, one edge after `rd_addr_i` is sampled, the byte stored at that address. Addresses 18 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 72 | Event inputs, four per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 8 | Registered read data |
| ack_i | input | 1 | CPU accepts the pending request |
| reti_i | input | 1 | CPU returns from the innermost service |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector address of the requested source |
| src_o | output | 5 | Index of the requested source |

## Verification
An event or a flag write at edge k changes the flag at edge k, so a read issued on the next cycle returns the new value one edge later. A request becomes due one edge after its flag is eligible. A level change caused by `ack_i` or `reti_i` at edge a first affects arbitration at edge a+1. The bench applies every stimulus at the falling edge and samples just after the next rising edge. A cycle model in the bench advances by one edge per stimulus, so each expected output is due exactly at the sample that follows. Directed sequences place the hand-computed values for ties, preemption, return and set-versus-clear on the cycle they fall due.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 18,
  parameter int EVT_W       = 4,
  parameter int NUM_GRP     = 6,
  parameter int ADDR_W      = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC*EVT_W-1:0]  evt_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [7:0]                wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [7:0]                rd_data_o,
  output logic [NUM_SRC-1:0]        flag_o,
  output logic [NUM_SRC-1:0]        ien_o,
  output logic                      gen_o,
  output logic [NUM_GRP*LVL_W-1:0]  pri_o
);
  localparam int FLG_BYTES = (NUM_SRC + 7) / 8;
  localparam int FLG_BASE  = 0;
  localparam int IEN_BASE  = FLG_BYTES;
  localparam int GEN_ADDR  = 2 * FLG_BYTES;
  localparam int PRI_BASE  = GEN_ADDR + 1;
  localparam int PRI_BITS  = NUM_GRP * LVL_W;
  localparam int PRI_BYTES = (PRI_BITS + 7) / 8;
  localparam int MSK_BASE  = PRI_BASE + PRI_BYTES;
  localparam int MSK_BITS  = NUM_SRC * EVT_W;
  localparam int MSK_BYTES = (MSK_BITS + 7) / 8;
  localparam int NUM_REGS  = MSK_BASE + MSK_BYTES;

  logic [NUM_SRC-1:0]  flag_q;
  logic [NUM_SRC-1:0]  ien_q;
  logic                gen_q;
  logic [PRI_BITS-1:0] pri_q;
  logic [MSK_BITS-1:0] msk_q;
  logic [NUM_REGS-1:0] sel_w;
  logic [7:0]          regmap [NUM_REGS];
  logic [7:0]          rd_q;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel_w[k] = wr_en_i && (wr_addr_i == ADDR_W'(k));
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
    logic hit, clr;
    assign hit = |(evt_i[s*EVT_W +: EVT_W] & msk_q[s*EVT_W +: EVT_W]);
    assign clr = sel_w[FLG_BASE + s/8] & wr_data_i[s%8];
    always_ff @(posedge clk) begin
      if (rst) flag_q[s] <= 1'b0;
      else     flag_q[s] <= hit | (flag_q[s] & ~clr);
    end
    always_ff @(posedge clk) begin
      if (rst)                      ien_q[s] <= 1'b0;
      else if (sel_w[IEN_BASE+s/8]) ien_q[s] <= wr_data_i[s%8];
    end
    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
      (!flag_q[s] && !hit) |=> !flag_q[s]); // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (hit && clr) |=> flag_q[s]); // R3
  end

  for (genvar b = 0; b < PRI_BITS; b++) begin : g_pri
    always_ff @(posedge clk) begin
      if (rst)                      pri_q[b] <= 1'b0;
      else if (sel_w[PRI_BASE+b/8]) pri_q[b] <= wr_data_i[b%8];
    end
  end

  for (genvar b = 0; b < MSK_BITS; b++) begin : g_msk
    always_ff @(posedge clk) begin
      if (rst)                      msk_q[b] <= 1'b0;
      else if (sel_w[MSK_BASE+b/8]) msk_q[b] <= wr_data_i[b%8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  gen_q <= 1'b0;
    else if (sel_w[GEN_ADDR]) gen_q <= wr_data_i[0];
  end

  logic [FLG_BYTES*8-1:0] flg_pad, ien_pad;
  logic [PRI_BYTES*8-1:0] pri_pad;
  logic [MSK_BYTES*8-1:0] msk_pad;
  assign flg_pad = (FLG_BYTES*8)'(flag_q);
  assign ien_pad = (FLG_BYTES*8)'(ien_q);
  assign pri_pad = (PRI_BYTES*8)'(pri_q);
  assign msk_pad = (MSK_BYTES*8)'(msk_q);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_map
    if (k < IEN_BASE) begin : g_f
      assign regmap[k] = flg_pad[8*(k-FLG_BASE) +: 8];
    end else if (k < GEN_ADDR) begin : g_e
      assign regmap[k] = ien_pad[8*(k-IEN_BASE) +: 8];
    end else if (k == GEN_ADDR) begin : g_g
      assign regmap[k] = {7'b0, gen_q};
    end else if (k < MSK_BASE) begin : g_p
      assign regmap[k] = pri_pad[8*(k-PRI_BASE) +: 8];
    end else begin : g_m
      assign regmap[k] = msk_pad[8*(k-MSK_BASE) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 rd_q <= '0;
    else if (rd_addr_i < ADDR_W'(NUM_REGS))  rd_q <= regmap[rd_addr_i];
    else                                     rd_q <= '0;
  end

  assign rd_data_o = rd_q;
  assign flag_o    = flag_q;
  assign ien_o     = ien_q;
  assign gen_o     = gen_q;
  assign pri_o     = pri_q;
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 18,
  parameter int SRC_PER_GRP = 3,
  parameter int NUM_GRP     = 6,
  parameter int IDX_W       = 5
) (
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_GRP*LVL_W-1:0] pri_i,
  input  logic                     cur_valid_i,
  input  lvl_t                     cur_lvl_i,
  output logic                     win_valid_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output lvl_t                     win_lvl_o
);
  lvl_t src_lvl [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
    assign src_lvl[s] = pri_i[LVL_W*(s/SRC_PER_GRP) +: LVL_W];
  end

  // Ascending scan with a strict compare: the lowest index keeps a tie.
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_lvl_o   = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pend_i[s] && (!cur_valid_i || src_lvl[s] > cur_lvl_i) &&
          (!win_valid_o || src_lvl[s] > win_lvl_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(s);
        win_lvl_o   = src_lvl[s];
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  lvl_t             win_lvl_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [IDX_W-1:0] src_o,
  output logic             cur_valid_o,
  output lvl_t             cur_lvl_o
);
  logic [NUM_LVL-1:0] in_svc, svc_n;
  logic               req_q;
  logic [IDX_W-1:0]   idx_q;
  logic [VEC_W-1:0]   vec_q;
  lvl_t               lvl_q;
  lvl_t               cur_lvl;

  always_comb begin
    cur_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (in_svc[l]) cur_lvl = lvl_t'(l);
  end

  always_comb begin
    svc_n = in_svc;
    if (reti_i && |in_svc) svc_n[cur_lvl] = 1'b0;
    if (req_q && ack_i)    svc_n[lvl_q]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_svc <= '0;
      req_q  <= 1'b0;
      idx_q  <= '0;
      lvl_q  <= '0;
      vec_q  <= '0;
    end else begin
      in_svc <= svc_n;
      if (req_q && ack_i) begin
        req_q <= 1'b0;
      end else if (!req_q && win_valid_i) begin
        req_q <= 1'b1;
        idx_q <= win_idx_i;
        lvl_q <= win_lvl_i;
        vec_q <= VEC_W'(VEC_BASE + VEC_STRIDE * int'(win_idx_i));
      end
    end
  end

  assign irq_o       = req_q;
  assign vec_o       = vec_q;
  assign src_o       = idx_q;
  assign cur_valid_o = |in_svc;
  assign cur_lvl_o   = cur_lvl;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (req_q && !ack_i) |=> (req_q && $stable(vec_q) && $stable(idx_q))); // R6
  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_q) && |in_svc) |-> (lvl_q > cur_lvl)); // R7
  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (req_q && ack_i) |=> in_svc[$past(lvl_q)]); // R7
  AST_SVC_GROWS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    ($countones(in_svc) > $countones($past(in_svc))) |-> $past(req_q && ack_i)); // R7
  AST_RETI_DROPS_TOP: assert property (@(posedge clk) disable iff (rst)
    (reti_i && |in_svc && !(req_q && ack_i)) |=> !in_svc[$past(cur_lvl)]); // R8
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 18,
  parameter int EVT_W       = 4,
  parameter int SRC_PER_GRP = 3,
  parameter int ADDR_W      = 5,
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC*EVT_W-1:0] evt_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [7:0]               wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  input  logic                     ack_i,
  input  logic                     reti_i,
  output logic                     irq_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic [IDX_W-1:0]         src_o
);
  localparam int NUM_GRP = (NUM_SRC + SRC_PER_GRP - 1) / SRC_PER_GRP;

  logic [NUM_SRC-1:0]       flag_w, ien_w, pend_w;
  logic                     gen_w;
  logic [NUM_GRP*LVL_W-1:0] pri_w;
  logic                     win_valid_w, cur_valid_w;
  logic [IDX_W-1:0]         win_idx_w;
  lvl_t                     win_lvl_w, cur_lvl_w;

  irq_regfile #(
    .NUM_SRC(NUM_SRC), .EVT_W(EVT_W), .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .flag_o(flag_w), .ien_o(ien_w), .gen_o(gen_w), .pri_o(pri_w)
  );

  assign pend_w = flag_w & ien_w & {NUM_SRC{gen_w}};

  irq_select #(
    .NUM_SRC(NUM_SRC), .SRC_PER_GRP(SRC_PER_GRP), .NUM_GRP(NUM_GRP), .IDX_W(IDX_W)
  ) u_sel (
    .pend_i(pend_w), .pri_i(pri_w),
    .cur_valid_i(cur_valid_w), .cur_lvl_i(cur_lvl_w),
    .win_valid_o(win_valid_w), .win_idx_o(win_idx_w), .win_lvl_o(win_lvl_w)
  );

  irq_nest #(
    .IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_nest (
    .clk(clk), .rst(rst),
    .win_valid_i(win_valid_w), .win_idx_i(win_idx_w), .win_lvl_i(win_lvl_w),
    .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .vec_o(vec_o), .src_o(src_o),
    .cur_valid_o(cur_valid_w), .cur_lvl_o(cur_lvl_w)
  );

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !gen_w |-> !win_valid_w); // R4
  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (rst)
    win_valid_w |-> (flag_w[win_idx_w] && ien_w[win_idx_w])); // R4
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 18;
  localparam int EW = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NS*EW-1:0] evt = '0;
  logic           wr_en = 1'b0;
  logic [4:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [4:0]     rd_addr = '0;
  logic           ack = 1'b0;
  logic           reti = 1'b0;
  logic [7:0]     rd_data;
  logic           irq;
  logic [7:0]     vec;
  logic [4:0]     src;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [NS-1:0]    m_flag, m_ien;
  logic             m_gen;
  logic [11:0]      m_pri;
  logic [NS*EW-1:0] m_msk;
  logic [3:0]       m_svc;
  logic             m_req;
  int               m_idx, m_lvl;
  logic [7:0]       m_rd;

  irq_ctrl dut_i (
    .clk(clk), .rst(rst), .evt_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_o(vec), .src_o(src)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input int a);
    logic [143:0] all;
    all = '0;
    all[NS-1:0]      = m_flag;
    all[24 +: NS]    = m_ien;
    all[48]          = m_gen;
    all[56 +: 12]    = m_pri;
    all[72 +: NS*EW] = m_msk;
    return (a < 18) ? all[8*a +: 8] : 8'h00;
  endfunction

  function automatic int m_top();
    int t = -1;
    for (int l = 0; l < 4; l++) if (m_svc[l]) t = l;
    return t;
  endfunction

  task automatic m_step();
    bit wv = 0; int wi = 0; int wl = 0; int top;
    logic [NS-1:0] fl_n; logic [3:0] svc_n;
    top = m_top();
    for (int s = 0; s < NS; s++) begin
      int l = int'(m_pri[2*(s/3) +: 2]);
      if (m_flag[s] && m_ien[s] && m_gen && (top < 0 || l > top) && (!wv || l > wl)) begin
        wv = 1; wi = s; wl = l;
      end
    end
    m_rd = m_read(int'(rd_addr));
    svc_n = m_svc;
    if (reti && top >= 0) svc_n[top] = 1'b0;
    if (m_req && ack) begin svc_n[m_lvl] = 1'b1; m_req = 0; end
    else if (!m_req && wv) begin m_req = 1; m_idx = wi; m_lvl = wl; end
    m_svc = svc_n;
    for (int s = 0; s < NS; s++) begin
      bit set = |(evt[s*EW +: EW] & m_msk[s*EW +: EW]);
      bit clr = wr_en && (int'(wr_addr) == s/8) && wr_data[s%8];
      fl_n[s] = set | (m_flag[s] & ~clr);
    end
    if (wr_en) begin
      int a = int'(wr_addr);
      for (int b = 0; b < 8; b++) begin
        if (a >= 3 && a <= 5 && (a-3)*8+b < NS) m_ien[(a-3)*8+b] = wr_data[b];
        if (a >= 7 && a <= 8 && (a-7)*8+b < 12) m_pri[(a-7)*8+b] = wr_data[b];
        if (a >= 9 && a <= 17) m_msk[(a-9)*8+b] = wr_data[b];
      end
      if (a == 6) m_gen = wr_data[0];
    end
    m_flag = fl_n;
  endtask

  task automatic compare(input string t_irq, input string t_vec, input string t_rd);
    chk(irq == m_req, t_irq, "irq_o", int'(irq), int'(m_req));
    if (m_req) begin
      chk(vec == 8'(3 + 8*m_idx), t_vec, "vec_o", int'(vec), 3 + 8*m_idx);
      chk(int'(src) == m_idx, t_vec, "src_o", int'(src), m_idx);
    end
    chk(rd_data == m_rd, t_rd, "rd_data_o", int'(rd_data), int'(m_rd));
  endtask

  task automatic drive(input logic [NS*EW-1:0] e, input bit we, input int wa,
                       input int wd, input int ra, input bit ak, input bit rt,
                       input string tag);
    @(negedge clk);
    evt = e; wr_en = we; wr_addr = 5'(wa); wr_data = 8'(wd);
    rd_addr = 5'(ra); ack = ak; reti = rt;
    @(posedge clk);
    #1;
    m_step();
    compare(tag, tag, tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    drive('0, 1, a, d, 0, 0, 0, tag);
  endtask

  task automatic idle(input int ra, input string tag);
    drive('0, 0, 0, 0, ra, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NS*EW-1:0] e;
    void'($urandom(32'h5eed_1c0d));
    m_flag = '0; m_ien = '0; m_gen = 0; m_pri = '0; m_msk = '0;
    m_svc = '0; m_req = 0; m_idx = 0; m_lvl = 0; m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk(irq == 1'b0, "R9", "irq_o after reset", int'(irq), 0);
    chk(rd_data == 8'h00, "R9", "rd_data after reset", int'(rd_data), 0);
    for (int a = 0; a < 20; a++) idle(a, "R9");

    // R2 and R1: src0 ev1 and src1 ev0 unmasked
    wr(9, 8'h12, "R2");
    e = '0; e[0] = 1'b1;
    drive(e, 0, 0, 0, 0, 0, 0, "R2");
    idle(0, "R2");
    chk(rd_data == 8'h00, "R2", "masked event flag", int'(rd_data), 0);
    e = '0; e[1] = 1'b1; e[4] = 1'b1;
    drive(e, 0, 0, 0, 0, 0, 0, "R1");
    idle(0, "R1");
    chk(rd_data == 8'h03, "R1", "flags after events", int'(rd_data), 3);

    // R3: clear, then set-and-clear together
    wr(0, 8'h02, "R3");
    idle(0, "R3");
    chk(rd_data == 8'h01, "R3", "flag after clear", int'(rd_data), 1);
    e = '0; e[4] = 1'b1;
    drive(e, 1, 0, 8'h02, 0, 0, 0, "R3");
    idle(0, "R3");
    chk(rd_data == 8'h03, "R3", "set beats clear", int'(rd_data), 3);

    // R4: enables without global enable
    wr(3, 8'h03, "R4");
    idle(0, "R4"); idle(0, "R4");
    chk(irq == 1'b0, "R4", "irq without global enable", int'(irq), 0);
    wr(6, 8'h01, "R4");
    idle(0, "R4");
    chk(irq == 1'b1, "R4", "irq after global enable", int'(irq), 1);
    chk(vec == 8'd3, "R5", "tie vector lowest index", int'(vec), 3);

    // R6 hold, R7 preemption, R8 return
    wr(7, 8'h08, "R6");
    wr(11, 8'h01, "R6");
    wr(3, 8'h13, "R6");
    e = '0; e[16] = 1'b1;
    drive(e, 0, 0, 0, 0, 0, 0, "R6");
    idle(0, "R6");
    chk(vec == 8'd3, "R6", "vector held until ack", int'(vec), 3);
    drive('0, 0, 0, 0, 0, 1, 0, "R6");
    chk(irq == 1'b0, "R6", "irq drops on ack", int'(irq), 0);
    idle(0, "R7");
    chk(irq == 1'b1 && vec == 8'd35, "R7", "preempting vector", int'(vec), 35);
    drive('0, 0, 0, 0, 0, 1, 0, "R7");
    idle(0, "R7"); idle(0, "R7");
    chk(irq == 1'b0, "R7", "no equal-level preemption", int'(irq), 0);
    drive('0, 0, 0, 0, 0, 0, 1, "R8");
    idle(0, "R8");
    chk(irq == 1'b1 && vec == 8'd35, "R8", "request after return", int'(vec), 35);
    drive('0, 0, 0, 0, 0, 1, 0, "R8");
    drive('0, 0, 0, 0, 0, 0, 1, "R8");
    drive('0, 0, 0, 0, 0, 0, 1, "R8");
    drive('0, 0, 0, 0, 0, 0, 1, "R8");
    wr(0, 8'hFF, "R3"); wr(2, 8'hFF, "R3");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 4) == 0;
      e = '0;
      for (int b = 0; b < NS*EW; b++) e[b] = ($urandom % 24) == 0;
      drive(e, we, int'($urandom % 20), int'($urandom % 256), int'($urandom % 21),
            ($urandom % 4) == 0, ($urandom % 8) == 0, "R5");
    end
    for (int a = 0; a < 20; a++) idle(a, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule